// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block converts a parallel data word into a serial frame that carries its own timing. A frame is the data word with a fixed high marker bit in front and a fixed low marker bit behind it. The guaranteed high-to-low edge at every frame boundary lets a receiver recover the word timing from the single serial line. The block runs on the bit-rate clock. A free-running slot counter divides that clock by the frame length, and the counter stands in for the parallel word clock. A mode input picks whether the word is captured at the start of the word period or at its midpoint, which models a choice between rising-edge and falling-edge capture.

Either of two OR-ed request lines replaces data frames with a synchronization symbol. The symbol is a run of ones followed by an equal run of zeros. A burst of symbols, once started, never lasts less than a programmable number of frames. An output-enable input and a power-down input gate a valid flag, which models the high-impedance state of the line driver. After power-down or reset the block waits a programmable number of word periods before any frame is marked valid.

Top module: `ecf_serializer`

## Requirements
- R1: A frame is FRAME = DATA_W + 2 bit cycles long. Bit 0 of the frame is the start marker and is always 1. Bits 1 to DATA_W carry data bits 0 to DATA_W-1, least significant bit first. The last bit is the stop marker and is always 0.
- R2: After reset or power-down is released, the first bit cycle is slot 0, and frames then repeat every FRAME cycles. The frame bit k appears on ser_o during slot k.
- R3: With edge_sel_i = 1 the word is taken from data_i in the slot-0 cycle. With edge_sel_i = 0 it is taken in the slot FRAME/2 cycle. The captured word goes out in the next frame. Changes of data_i in any other cycle have no effect on that frame.
- R4: A synchronization frame holds ones in bits 0 to FRAME/2-1 and zeros in the remaining bits.
- R5: sync_a_i OR sync_b_i is sampled in the last slot of every frame. A request seen at n consecutive frame ends yields exactly n + MIN_SYNC - 1 synchronization frames, and then data frames resume. A single sampled request therefore yields MIN_SYNC frames.
- R6: If oe_i is low at a clock edge, valid_o is low after that edge. Frame progress continues while the output is disabled. When oe_i returns high, the output resumes at the current bit of the current frame.
- R7: While pwr_i is low, valid_o stays low and the slot count is held at 0. Reset behaves the same way. After release, valid_o first rises (INIT_WORDS + 1) * FRAME cycles later, on a start bit.
- R8: ser_o is 0 whenever valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Parallel data word |
| sync_a_i | input | 1 | Synchronization request, first line |
| sync_b_i | input | 1 | Synchronization request, second line |
| oe_i | input | 1 | Output enable, active high |
| pwr_i | input | 1 | Power control; low stops the block |
| edge_sel_i | input | 1 | Capture phase: 1 at slot 0, 0 at slot FRAME/2 |
| ser_o | output | 1 | Serial bit |
| valid_o | output | 1 | Output driven (low models high impedance) |

## Verification
The bench builds the block with DATA_W = 4, MIN_SYNC = 3 and INIT_WORDS = 2. That gives a six-bit frame and short burst and start-up windows. With these values every possible data word can be sent under both capture phases, each with a corrupting change right after capture. The exact number of synchronization frames can be counted for single and held requests on either line. The full start-up wait after reset and after power-down can also be timed to the cycle.

// File: rtl/ecf_pkg.sv
package ecf_pkg;

  // Width of a down-counter that must hold the value n.
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // Two marker bits wrap every data word.
  function automatic int frame_len(input int dw);
    return dw + 2;
  endfunction

endpackage

// File: rtl/ecf_slot_timer.sv
module ecf_slot_timer #(
  parameter int FRAME  = 12,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_i,
  input  logic              edge_sel_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic              load_o,
  output logic              cap_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME - 1);
  localparam logic [SLOT_W-1:0] MID_SLOT  = SLOT_W'(FRAME / 2);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      slot_q <= '0;
    end else if (slot_q == LAST_SLOT) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign slot_o = slot_q;
  assign load_o = pwr_i && (slot_q == LAST_SLOT);
  assign cap_o  = pwr_i && (edge_sel_i ? (slot_q == '0) : (slot_q == MID_SLOT));
endmodule

// File: rtl/ecf_sync_ctrl.sv
module ecf_sync_ctrl #(
  parameter int MIN_SYNC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_i,
  input  logic load_i,
  input  logic req_a_i,
  input  logic req_b_i,
  output logic send_o
);
  localparam int CW = ecf_pkg::cnt_w(MIN_SYNC);
  localparam logic [CW-1:0] TAIL = CW'(MIN_SYNC - 1);

  logic [CW-1:0] left_q;
  logic          req;

  assign req    = req_a_i | req_b_i;
  assign send_o = req || (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      left_q <= '0;
    end else if (load_i) begin
      if (req) begin
        left_q <= TAIL;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecf_init_ctrl.sv
module ecf_init_ctrl #(
  parameter int INIT_WORDS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_i,
  input  logic load_i,
  output logic ready_nxt_o
);
  localparam int IW = ecf_pkg::cnt_w(INIT_WORDS);
  localparam logic [IW-1:0] START = IW'(INIT_WORDS);

  logic [IW-1:0] wait_q;
  logic          ready_q;

  assign ready_nxt_o = pwr_i && (ready_q || (load_i && (wait_q == '0)));

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      wait_q  <= START;
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_nxt_o;
      if (load_i && (wait_q != '0)) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecf_frame_shifter.sv
module ecf_frame_shifter #(
  parameter int DATA_W = 10,
  parameter int FRAME  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_i,
  input  logic              oe_i,
  input  logic              cap_i,
  input  logic              load_i,
  input  logic              sync_i,
  input  logic              ready_nxt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ser_o,
  output logic              valid_o
);
  localparam int HALF = FRAME / 2;

  logic [DATA_W-1:0] hold_q;
  logic [FRAME-1:0]  data_frm;
  logic [FRAME-1:0]  sync_frm;
  logic [FRAME-1:0]  frame_w;
  logic [FRAME-1:0]  sh_q;
  logic              bit_nxt;
  logic              vld_nxt;
  logic              ser_q;
  logic              valid_q;

  for (genvar i = 0; i < FRAME; i++) begin : g_frm
    if (i == 0) begin : g_start
      assign data_frm[i] = 1'b1;
    end else if (i == FRAME - 1) begin : g_stop
      assign data_frm[i] = 1'b0;
    end else begin : g_data
      assign data_frm[i] = hold_q[i-1];
    end
    assign sync_frm[i] = (i < HALF);
  end

  assign frame_w = sync_i ? sync_frm : data_frm;
  assign bit_nxt = load_i ? frame_w[0] : sh_q[1];
  assign vld_nxt = pwr_i && oe_i && ready_nxt_i;

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      hold_q <= '0;
    end else if (cap_i) begin
      hold_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_i) begin
      sh_q <= '0;
    end else if (load_i) begin
      sh_q <= frame_w;
    end else begin
      sh_q <= sh_q >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ser_q   <= vld_nxt && bit_nxt;
      valid_q <= vld_nxt;
    end
  end

  assign ser_o   = ser_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ecf_serializer.sv
module ecf_serializer #(
  parameter int DATA_W     = 10,
  parameter int MIN_SYNC   = 1024,
  parameter int INIT_WORDS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              oe_i,
  input  logic              pwr_i,
  input  logic              edge_sel_i,
  output logic              ser_o,
  output logic              valid_o
);
  localparam int FRAME  = ecf_pkg::frame_len(DATA_W);
  localparam int SLOT_W = $clog2(FRAME);

  logic [SLOT_W-1:0] slot_q;
  logic              load;
  logic              cap;
  logic              send_sync;
  logic              ready_nxt;

  ecf_slot_timer #(.FRAME(FRAME), .SLOT_W(SLOT_W)) timer_i (
    .clk(clk), .rst(rst), .pwr_i(pwr_i), .edge_sel_i(edge_sel_i),
    .slot_o(slot_q), .load_o(load), .cap_o(cap)
  );

  ecf_sync_ctrl #(.MIN_SYNC(MIN_SYNC)) sync_i (
    .clk(clk), .rst(rst), .pwr_i(pwr_i), .load_i(load),
    .req_a_i(sync_a_i), .req_b_i(sync_b_i), .send_o(send_sync)
  );

  ecf_init_ctrl #(.INIT_WORDS(INIT_WORDS)) init_i (
    .clk(clk), .rst(rst), .pwr_i(pwr_i), .load_i(load),
    .ready_nxt_o(ready_nxt)
  );

  ecf_frame_shifter #(.DATA_W(DATA_W), .FRAME(FRAME)) shift_i (
    .clk(clk), .rst(rst), .pwr_i(pwr_i), .oe_i(oe_i),
    .cap_i(cap), .load_i(load), .sync_i(send_sync),
    .ready_nxt_i(ready_nxt), .data_i(data_i),
    .ser_o(ser_o), .valid_o(valid_o)
  );
endmodule

// File: rtl/ecf_serializer_chk.sv
module ecf_serializer_chk #(
  parameter int FL = 12,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          oe_i,
  input logic          pwr_i,
  input logic          ser_o,
  input logic          valid_o,
  input logic [SW-1:0] slot_q
);
  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && slot_q == '0) |-> ser_o);

  // R1
  stop_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && slot_q == SW'(FL - 1)) |-> !ser_o);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> !ser_o);

  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_i |=> !valid_o);

  // R7
  pd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_i |=> (!valid_o && slot_q == '0));
endmodule

bind ecf_serializer ecf_serializer_chk #(.FL(FRAME), .SW(SLOT_W)) chk_i (
  .clk(clk), .rst(rst), .oe_i(oe_i), .pwr_i(pwr_i),
  .ser_o(ser_o), .valid_o(valid_o), .slot_q(slot_q)
);

// File: tb/ecf_serializer_tb.sv
module ecf_serializer_tb_top;
  localparam int DW   = 4;
  localparam int MS   = 3;
  localparam int IW   = 2;
  localparam int F    = DW + 2;
  localparam int H    = F / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] data = '0;
  logic          sync_a = 1'b0;
  logic          sync_b = 1'b0;
  logic          oe = 1'b1;
  logic          pwr = 1'b1;
  logic          edge_sel = 1'b1;
  logic          ser;
  logic          valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int bslot = 0;

  always #5 clk = ~clk;

  ecf_serializer #(.DATA_W(DW), .MIN_SYNC(MS), .INIT_WORDS(IW)) dut_i (
    .clk(clk), .rst(rst), .data_i(data), .sync_a_i(sync_a), .sync_b_i(sync_b),
    .oe_i(oe), .pwr_i(pwr), .edge_sel_i(edge_sel), .ser_o(ser), .valid_o(valid)
  );

  // Slot position as stated in R2.
  always @(posedge clk) begin
    if (rst || !pwr) bslot <= 0;
    else bslot <= (bslot == F - 1) ? 0 : bslot + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_slot(input int k);
    do @(negedge clk); while (bslot != k);
  endtask

  function automatic logic [F-1:0] exp_data(input logic [DW-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [F-1:0] exp_sync();
    return F'((1 << H) - 1);
  endfunction

  // Called at a negedge with bslot == 0; ends at bslot == F-1.
  task automatic check_frame(input logic [F-1:0] exp, input string tag);
    logic [F-1:0] got;
    bit all_v = 1'b1;
    for (int i = 0; i < F; i++) begin
      got[i] = ser;
      all_v  = all_v && valid;
      if (i < F - 1) @(negedge clk);
    end
    check(all_v && got == exp, tag, {all_v, got}, {1'b1, exp});
  endtask

  task automatic time_release(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!valid && n < 200);
    check(n == (IW + 1) * F, tag, n, (IW + 1) * F);
    check(ser == 1'b1 && bslot == 0, "R7 first valid bit is start", ser, 1);
  endtask

  task automatic sync_burst(input int held, input bit use_a);
    wait_slot(F - 1);
    if (use_a) sync_a = 1'b1; else sync_b = 1'b1;
    for (int j = 0; j < held + MS - 1; j++) begin
      wait_slot(0);
      if (j == held - 1) begin
        sync_a = 1'b0;
        sync_b = 1'b0;
      end
      check_frame(exp_sync(), "R4 R5 sync frame in burst");
    end
    wait_slot(0);
    check_frame(exp_data(data), "R5 data resumes after burst");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R7 valid low in reset", valid, 0);
    check(ser == 1'b0, "R8 serial low in reset", ser, 0);
    rst = 1'b0;
    time_release("R7 start-up latency after reset");

    // R1 R2 R3: every word under both capture phases.
    for (int m = 1; m >= 0; m--) begin
      edge_sel = m[0];
      for (int d = 0; d < (1 << DW); d++) begin
        wait_slot(m[0] ? 0 : H);
        data = DW'(d);
        @(negedge clk);
        data = ~DW'(d);
        wait_slot(0);
        check_frame(exp_data(DW'(d)), m[0] ? "R1 R3 frame, start capture" : "R1 R3 frame, mid capture");
      end
    end

    // R4 R5: one sampled request, then a held request on the other line.
    edge_sel = 1'b1;
    data = 4'h5;
    sync_burst(1, 1'b0);
    sync_burst(3, 1'b1);

    // R6: disable in the middle of a frame, then resume.
    data = 4'hA;
    wait_slot(0);
    wait_slot(0);
    @(negedge clk);
    @(negedge clk);
    oe = 1'b0;
    @(negedge clk);
    check(!valid && !ser, "R6 R8 disabled output", {valid, ser}, 0);
    @(negedge clk);
    check(!valid && !ser, "R6 R8 still disabled", {valid, ser}, 0);
    oe = 1'b1;
    @(negedge clk);
    check(valid && ser == exp_data(4'hA)[5], "R6 resume at frame bit 5", {valid, ser}, {1'b1, exp_data(4'hA)[5]});

    // R7: power-down restarts the timeline and the start-up wait.
    wait_slot(2);
    pwr = 1'b0;
    sync_a = 1'b1;
    repeat (3) @(negedge clk);
    check(!valid && !ser, "R7 powered down output", {valid, ser}, 0);
    sync_a = 1'b0;
    pwr = 1'b1;
    time_release("R7 start-up latency after power-down");
    wait_slot(0);
    check_frame(exp_data(4'hA), "R1 R2 frame after power-up");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule